// File: doc/BRIEF.md
# Lane-Partitioned Parallel Bit Extract Unit

This unit splits a wide data word and an equally wide mask word into lanes of equal width. The lane width is chosen for each operation by a 2-bit size code. Inside every lane it picks out the data bits whose mask bit is set. It then packs them, in their original order, into the low end of the matching result lane and clears the bits above them. Every lane is handled on its own, and no bit crosses a lane edge.

An operation is presented with a single valid-in pulse. The size code, data and mask are all sampled on that cycle. The result comes back from one register stage one cycle later, together with a one-cycle valid-out, so a new operation can be issued on every clock. The operation is unpredicated: every lane of the result is rewritten on every accepted operation.

Top module: `pext_unit`

## Requirements
- R1: The size code `size_i` picks the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. The lane count is `VEC_W` divided by the lane width, and lane k covers bits k*width up to (k+1)*width-1. The code is sampled in the same cycle as `data_i` and `mask_i`.
- R2: Within a lane, each data bit whose mask bit is 1 goes to result position p, where p is the number of set mask bits below it inside that lane. The selected bits therefore fill consecutive positions starting at the lane's bit 0.
- R3: Selected bits keep their relative order: a selected bit from a lower source position always lands lower in the result than one from a higher position.
- R4: Result bits of a lane above the packed bits are 0. A lane whose mask is all zeros yields an all-zero result lane.
- R5: A lane whose mask is all ones returns its data unchanged.
- R6: Lanes are independent. The mask and data of one lane never affect the result bits of another lane.
- R7: For every cycle with `valid_i` high, `valid_o` is high for exactly one cycle in the following cycle, with `res_o` holding that operation's result. Operations may be issued on consecutive cycles.
- R8: A synchronous active-high `rst` clears `valid_o` and `res_o` to 0 at the next clock edge, whatever `valid_i` is.
- R9: In a cycle with `valid_i` low, `res_o` keeps its previous value and `valid_o` goes low on the next edge.
- R10: Every accepted operation rewrites all `VEC_W` result bits, and no bit of a previous result survives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation present this cycle |
| size_i | input | 2 | Lane size code (0:8, 1:16, 2:32, 3:64 bits) |
| data_i | input | VEC_W | Source data vector |
| mask_i | input | VEC_W | Selection mask vector |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| res_o | output | VEC_W | Packed per-lane result |

## Verification
The only internal state besides the output register is the per-bit rank chain. That chain is rebuilt from scratch on every operation, so a fault in it shows up in `res_o` on the cycle right after the offending `valid_i`. A rank that fails to restart at a lane edge sends bits into the wrong lane, or leaves a lane's low bits empty, and that is visible at once under the single-bit and alternating masks. A result register that fails to load or to hold shows up as a stale value either on the next valid cycle or on the first idle cycle after it.

// File: rtl/pext_pkg.sv
package pext_pkg;

    // Each group of 64 bits is processed by its own group unit; lanes never exceed a group.
    localparam int GRP_W = 64;
    localparam int IDX_W = $clog2(GRP_W);

    typedef enum logic [1:0] {
        LANE8  = 2'd0,
        LANE16 = 2'd1,
        LANE32 = 2'd2,
        LANE64 = 2'd3
    } lane_sz_e;

    typedef logic [IDX_W-1:0] bit_idx_t;

    typedef struct packed {
        lane_sz_e           sz;
        logic [GRP_W-1:0]   data;
        logic [GRP_W-1:0]   mask;
    } grp_req_t;

    // Lane width in bits for a size code.
    function automatic logic [IDX_W:0] lane_width(lane_sz_e sz);
        return (IDX_W+1)'(8) << sz;
    endfunction

    // Low-bit mask covering the index bits inside one lane.
    function automatic bit_idx_t lane_low_bits(lane_sz_e sz);
        logic [IDX_W:0] w;
        w = lane_width(sz) - 1'b1;
        return w[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/pext_rank.sv
module pext_rank
    import pext_pkg::*;
(
    input  lane_sz_e                 sz_i,
    input  logic [GRP_W-1:0]         mask_i,
    output bit_idx_t [GRP_W-1:0]     rank_o
);

    bit_idx_t low_bits;
    bit_idx_t run;

    assign low_bits = lane_low_bits(sz_i);

    // Prefix count of set mask bits, restarted at every lane start.
    always_comb begin
        run = '0;
        for (int i = 0; i < GRP_W; i++) begin
            if ((bit_idx_t'(i) & low_bits) == '0) begin
                run = '0;
            end
            rank_o[i] = run;
            run = run + bit_idx_t'(mask_i[i]);
        end
    end

endmodule

// File: rtl/pext_group.sv
module pext_group
    import pext_pkg::*;
(
    input  grp_req_t            req_i,
    output logic [GRP_W-1:0]    res_o
);

    bit_idx_t [GRP_W-1:0] rank;
    bit_idx_t [GRP_W-1:0] dest;
    logic     [GRP_W-1:0] sel;
    bit_idx_t             low_bits;

    pext_rank u_rank (
        .sz_i   (req_i.sz),
        .mask_i (req_i.mask),
        .rank_o (rank)
    );

    assign low_bits = lane_low_bits(req_i.sz);
    assign sel      = req_i.mask & req_i.data;

    // Destination inside the group: lane base plus rank within the lane.
    always_comb begin
        for (int i = 0; i < GRP_W; i++) begin
            dest[i] = (bit_idx_t'(i) & ~low_bits) | rank[i];
        end
    end

    // Scatter: a bit never moves up, so only sources at or above j can reach j.
    always_comb begin
        for (int j = 0; j < GRP_W; j++) begin
            res_o[j] = 1'b0;
            for (int i = j; i < GRP_W; i++) begin
                if (sel[i] && dest[i] == bit_idx_t'(j)) begin
                    res_o[j] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pext_unit.sv
module pext_unit
    import pext_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [1:0]       size_i,
    input  logic [VEC_W-1:0] data_i,
    input  logic [VEC_W-1:0] mask_i,
    output logic             valid_o,
    output logic [VEC_W-1:0] res_o
);

    localparam int NGRP = VEC_W / GRP_W;

    lane_sz_e         sz;
    logic [VEC_W-1:0] res_next;

    assign sz = lane_sz_e'(size_i);

    generate
        if (VEC_W % GRP_W != 0 || VEC_W == 0) begin : g_bad_width
            $error("VEC_W must be a non-zero multiple of 64");
        end
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            grp_req_t req;
            assign req.sz   = sz;
            assign req.data = data_i[g*GRP_W +: GRP_W];
            assign req.mask = mask_i[g*GRP_W +: GRP_W];
            pext_group u_group (
                .req_i (req),
                .res_o (res_next[g*GRP_W +: GRP_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            res_o   <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                res_o <= res_next;
            end
        end
    end

    // R7: one valid out for each valid in, one cycle later
    p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);
    // R8: reset clears the output stage
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!valid_o && res_o == '0));
    // R9: result held while idle
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(res_o));
    // R4: empty mask gives empty result
    p_zero_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mask_i == '0) |=> res_o == '0);
    // R5: full mask passes data through
    p_ones_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && &mask_i) |=> res_o == $past(data_i));
    // R2: every selected one arrives, nothing else is set
    p_bit_count_r2: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> $countones(res_o) == $past($countones(data_i & mask_i)));

endmodule

// File: tb/pext_unit_bench.sv
module pext_unit_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int VEC_W = 128;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             valid_i = 1'b0;
    logic [1:0]       size_i = 2'd0;
    logic [VEC_W-1:0] data_i = '0;
    logic [VEC_W-1:0] mask_i = '0;
    logic             valid_o;
    logic [VEC_W-1:0] res_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [VEC_W-1:0] last_res = '0;

    pext_unit #(.VEC_W(VEC_W)) u_pext_unit (
        .clk     (clk),
        .rst     (rst),
        .valid_i (valid_i),
        .size_i  (size_i),
        .data_i  (data_i),
        .mask_i  (mask_i),
        .valid_o (valid_o),
        .res_o   (res_o)
    );

    always #2 clk = ~clk;  // 250 MHz

    // Bit-serial reference: walk each lane, append selected bits upward.
    function automatic logic [VEC_W-1:0] ref_extract(logic [1:0] sz, logic [VEC_W-1:0] d,
                                                     logic [VEC_W-1:0] m);
        logic [VEC_W-1:0] r = '0;
        int lw = 8 << sz;
        for (int base = 0; base < VEC_W; base += lw) begin
            int k = 0;
            for (int b = 0; b < lw; b++) begin
                if (m[base+b]) begin
                    r[base+k] = d[base+b];
                    k++;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] rnd_vec();
        logic [VEC_W-1:0] v;
        for (int i = 0; i < VEC_W/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [VEC_W-1:0] act,
                         input logic [VEC_W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] sz, input logic [VEC_W-1:0] d,
                      input logic [VEC_W-1:0] m, input string tag);
        logic [VEC_W-1:0] exp;
        exp = ref_extract(sz, d, m);
        @(negedge clk);
        valid_i = 1'b1; size_i = sz; data_i = d; mask_i = m;
        @(posedge clk); #1;
        check(valid_o == 1'b1, {tag, " R7 valid_o"}, {127'd0, valid_o}, 128'd1);
        check(res_o == exp, tag, res_o, exp);
        last_res = exp;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        valid_i = 1'b0; data_i = rnd_vec(); mask_i = rnd_vec(); size_i = 2'(3 - size_i);
        @(posedge clk); #1;
        check(valid_o == 1'b0, {tag, " R7 valid_o low"}, {127'd0, valid_o}, 128'd0);
        check(res_o == last_res, {tag, " R9 hold"}, res_o, last_res);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1b2e_77c3));
        // R8: reset with valid held high
        valid_i = 1'b1; data_i = '1; mask_i = '1;
        repeat (3) @(posedge clk);
        #1;
        check(valid_o == 1'b0, "R8 reset valid_o", {127'd0, valid_o}, 128'd0);
        check(res_o == '0, "R8 reset res_o", res_o, '0);
        @(negedge clk); rst = 1'b0; valid_i = 1'b0;

        for (int s = 0; s < 4; s++) begin
            logic [VEC_W-1:0] single = '0;
            logic [VEC_W-1:0] top = '0;
            int lw = 8 << s;
            for (int b = 0; b < VEC_W; b += lw) begin
                single[b+lw-1] = 1'b1;   // top bit of each lane
                top[b + lw/2] = 1'b1;
            end
            op(2'(s), rnd_vec(), '0, "R4 zero mask");
            op(2'(s), rnd_vec(), '1, "R5 ones mask");
            op(2'(s), '1, single, "R6 top bit per lane");
            op(2'(s), rnd_vec(), top, "R1/R2 mid bit per lane");
            op(2'(s), rnd_vec(), {(VEC_W/2){2'b10}}, "R3 alternating 10");
            op(2'(s), rnd_vec(), {(VEC_W/2){2'b01}}, "R3 alternating 01");
            op(2'(s), {(VEC_W/2){2'b10}}, rnd_vec(), "R2/R3 alternating data");
            idle("idle after directed");
        end

        // R1: same operands under every size code
        begin
            logic [VEC_W-1:0] d = rnd_vec();
            logic [VEC_W-1:0] m = rnd_vec();
            for (int s = 0; s < 4; s++) op(2'(s), d, m, "R1 size sweep");
        end

        // R10: full replacement after an all-ones result
        op(2'd3, '1, '1, "R10 prime");
        op(2'd0, '0, rnd_vec(), "R10 overwrite");

        // Random back-to-back traffic with varied mask density
        for (int n = 0; n < 240; n++) begin
            logic [VEC_W-1:0] m;
            case (n % 3)
                0: m = rnd_vec();
                1: m = rnd_vec() & rnd_vec();
                default: m = rnd_vec() | rnd_vec();
            endcase
            op(2'($urandom_range(0, 3)), rnd_vec(), m, "R2/R3/R4/R6 random");
            if (n % 17 == 0) idle("idle random");
        end

        // R8: mid-run reset overrides a valid operation
        @(negedge clk);
        rst = 1'b1; valid_i = 1'b1; mask_i = '1; data_i = '1;
        @(posedge clk); #1;
        check(valid_o == 1'b0, "R8 mid-run valid_o", {127'd0, valid_o}, 128'd0);
        check(res_o == '0, "R8 mid-run res_o", res_o, '0);
        @(negedge clk); rst = 1'b0; valid_i = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule